// File: doc/BRIEF.md
# Dual-Instruction Prefetch Queue

This block sits between a 32-bit instruction fetch bus and the decode stage of a core whose instructions are 16 bits wide. Each fetch returns one 32-bit word that carries two instructions. The block keeps up to four instructions in a small halfword queue, organised as two levels of two. It hands them to the instruction register one per handshake, so decode is not held up by single 16-bit fetches. Because every bus transfer fills two slots, the block needs about half the fetch transactions, which leaves more bus time for other masters.

The block stays idle after reset until the first redirect supplies a target address. A redirect empties the queue and marks every fetch still in flight as void, so the responses to those fetches are dropped when they return. The next fetch goes to the word that contains the target. If the target points at the second halfword of that word, the first halfword of the first returned word is thrown away. A fetch controller built as a three-state machine tracks this stream condition. PF_IDLE means no stream has been set up yet. PF_ODD means the stream started on a misaligned target and the first useful word has not yet arrived. PF_STREAM is normal running.

The transitions are: IDLE to ODD or STREAM on a redirect, depending on target bit 1. ODD to STREAM when the first response of the current stream arrives. From ODD or STREAM, a redirect goes back to ODD or STREAM, again chosen by target bit 1. Responses are assumed to come back in request order and are always accepted.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, and until the first redirect, fetch_req_valid and ir_valid stay low.
- R2: A fetch request is raised only if the queued halfwords, plus two for each live fetch in flight, plus two for the new fetch, fit in the 4-slot queue. The queue never overflows.
- R3: Each response word yields two instructions. Bits [31:16] (the lower address) are presented before bits [15:0], and instructions leave in fetch order, one per ir_valid/ir_ready handshake.
- R4: ir_valid is high exactly when the queue holds at least one instruction. With an empty queue nothing is presented.
- R5: In the cycle after redir_valid, ir_valid is low. A handshake on the decode side in the redirect cycle does not remove anything.
- R6: Responses to fetches accepted before or in the same cycle as a redirect are discarded. The first instruction after a redirect is the one at the target.
- R7: Fetch addresses are word-aligned. The first fetch after a redirect uses the target with bits [1:0] cleared, and each later fetch adds 4.
- R8: If target bit 1 is set, only bits [15:0] of the first word of the new stream enter the queue.
- R9: Fetches in flight, live and voided together, never exceed 4.
- R10: A request that is not accepted keeps fetch_req_valid high and fetch_req_addr unchanged in the next cycle, unless a redirect intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Flush and restart the stream at redir_addr |
| redir_addr | input | 32 | Byte address of the new instruction stream (bit 0 ignored) |
| fetch_req_valid | output | 1 | Fetch request pending |
| fetch_req_ready | input | 1 | Bus accepts the request |
| fetch_req_addr | output | 32 | Word address of the fetch |
| fetch_rsp_valid | input | 1 | Response word present (always accepted, in order) |
| fetch_rsp_data | input | 32 | Two instructions, lower address in [31:16] |
| ir_valid | output | 1 | An instruction is offered to decode |
| ir_ready | input | 1 | Decode takes the instruction |
| ir_data | output | 16 | Instruction at the head of the queue |

## Verification
The hard case is a redirect that coincides with a fetch being accepted, a response returning and decode popping the queue, all in one cycle. The bench sweeps bus latency, request-accept patterns and decode-ready patterns. It schedules periodic and back-to-back redirects, so every pairing of flush with push, pop and request acceptance happens many times. A bench model tags each bus transaction with a stream epoch and tracks queue occupancy. Every delivered instruction must equal the arithmetic content of the expected halfword address, and any voided response that leaked into the queue would show up as a data mismatch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        PF_IDLE   = 2'd0,
        PF_ODD    = 2'd1,
        PF_STREAM = 2'd2
    } pf_state_e;
endpackage

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DEPTH      = 4,
    parameter int MAX_FLIGHT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         redirect_valid,
    input  logic [AW-1:0]                redirect_addr,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic [AW-1:0]                req_addr,
    input  logic                         rsp_valid,
    input  logic [$clog2(DEPTH+1)-1:0]   q_count,
    output logic                         push_two,
    output logic                         push_one
);
    localparam int QCW = $clog2(DEPTH + 1);
    localparam int CW  = $clog2(MAX_FLIGHT + 1);
    localparam int UW  = QCW + CW + 1;
    localparam logic [UW-1:0] ROOM_LIMIT = UW'(DEPTH - 2);
    localparam logic [CW:0]   FLIGHT_CAP = (CW+1)'(MAX_FLIGHT);

    pf_state_e         state, state_nxt;
    logic [CW-1:0]     live_cnt, drop_cnt;
    logic [AW-1:0]     fetch_addr;
    logic [UW-1:0]     slots_used;
    logic [CW:0]       in_flight;
    logic              req_fire, rsp_live;

    assign slots_used = UW'(q_count) + UW'({live_cnt, 1'b0});
    assign in_flight  = {1'b0, drop_cnt} + {1'b0, live_cnt};
    assign req_fire   = req_valid & req_ready;
    assign rsp_live   = rsp_valid & ~redirect_valid & (drop_cnt == '0);
    assign req_addr   = fetch_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PF_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PF_IDLE: begin
                if (redirect_valid) state_nxt = redirect_addr[1] ? PF_ODD : PF_STREAM;
            end
            PF_ODD: begin
                if (redirect_valid)  state_nxt = redirect_addr[1] ? PF_ODD : PF_STREAM;
                else if (rsp_live)   state_nxt = PF_STREAM;
            end
            PF_STREAM: begin
                if (redirect_valid)  state_nxt = redirect_addr[1] ? PF_ODD : PF_STREAM;
            end
            default: state_nxt = PF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        push_two  = 1'b0;
        push_one  = 1'b0;
        unique case (state)
            PF_IDLE: ;
            PF_ODD: begin
                req_valid = (slots_used <= ROOM_LIMIT) && (in_flight < FLIGHT_CAP);
                push_one  = rsp_live;
            end
            PF_STREAM: begin
                req_valid = (slots_used <= ROOM_LIMIT) && (in_flight < FLIGHT_CAP);
                push_two  = rsp_live;
            end
            default: ;
        endcase
    end

    // fetch bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt   <= '0;
            drop_cnt   <= '0;
            fetch_addr <= '0;
        end else if (redirect_valid) begin
            live_cnt   <= '0;
            drop_cnt   <= CW'(in_flight + (CW+1)'(req_fire) - (CW+1)'(rsp_valid));
            fetch_addr <= {redirect_addr[AW-1:2], 2'b00};
        end else begin
            live_cnt   <= CW'({1'b0, live_cnt} + (CW+1)'(req_fire) - (CW+1)'(rsp_live));
            if (rsp_valid && drop_cnt != '0) drop_cnt <= drop_cnt - CW'(1);
            if (req_fire) fetch_addr <= fetch_addr + AW'(4);
        end
    end

    // R9: fetches in flight stay within the cap
    p_flight_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= FLIGHT_CAP)
        else $error("R9 in-flight fetch count above cap");

    // R10: a stalled request holds
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !redirect_valid) |=> (req_valid && $stable(req_addr)))
        else $error("R10 stalled request dropped or changed");
endmodule

// File: rtl/pfq_slot_queue.sv
module pfq_slot_queue #(
    parameter int DEPTH = 4,
    parameter int IW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push_two,
    input  logic                       push_one,
    input  logic [2*IW-1:0]            word_in,
    output logic                       out_valid,
    input  logic                       pop_ready,
    output logic [IW-1:0]              out_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [IW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr, wr_nxt;
    logic [CW-1:0] add_n;
    logic          pop;

    assign wr_nxt    = wr_ptr + PW'(1);
    assign out_valid = (count != '0);
    assign out_data  = slot[rd_ptr];
    assign pop       = out_valid & pop_ready & ~flush;
    assign add_n     = push_two ? CW'(2) : (push_one ? CW'(1) : '0);

    // lower-addressed halfword [2*IW-1:IW] goes in first
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_two && wr_ptr == PW'(i))
                slot[i] <= word_in[2*IW-1:IW];
            else if (push_two && wr_nxt == PW'(i))
                slot[i] <= word_in[IW-1:0];
            else if (push_one && wr_ptr == PW'(i))
                slot[i] <= word_in[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop)           rd_ptr <= rd_ptr + PW'(1);
            if (push_two)      wr_ptr <= wr_ptr + PW'(2);
            else if (push_one) wr_ptr <= wr_ptr + PW'(1);
            count <= count + add_n - CW'(pop);
        end
    end

    // R2: room for a pair was reserved before the fetch was issued
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_two |-> (count <= CW'(DEPTH - 2)))
        else $error("R2 pair pushed into a full queue");
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int AW         = 32,
    parameter int IW         = 16,
    parameter int SLOTS      = 4,
    parameter int MAX_FLIGHT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redir_valid,
    input  logic [AW-1:0]   redir_addr,
    output logic            fetch_req_valid,
    input  logic            fetch_req_ready,
    output logic [AW-1:0]   fetch_req_addr,
    input  logic            fetch_rsp_valid,
    input  logic [2*IW-1:0] fetch_rsp_data,
    output logic            ir_valid,
    input  logic            ir_ready,
    output logic [IW-1:0]   ir_data
);
    localparam int QCW = $clog2(SLOTS + 1);

    logic [QCW-1:0] q_count;
    logic           push_two, push_one;

    pfq_fetch_ctrl #(
        .AW(AW), .DEPTH(SLOTS), .MAX_FLIGHT(MAX_FLIGHT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redir_valid), .redirect_addr(redir_addr),
        .req_valid(fetch_req_valid), .req_ready(fetch_req_ready), .req_addr(fetch_req_addr),
        .rsp_valid(fetch_rsp_valid), .q_count(q_count),
        .push_two(push_two), .push_one(push_one)
    );

    pfq_slot_queue #(
        .DEPTH(SLOTS), .IW(IW)
    ) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(redir_valid),
        .push_two(push_two), .push_one(push_one), .word_in(fetch_rsp_data),
        .out_valid(ir_valid), .pop_ready(ir_ready), .out_data(ir_data),
        .count(q_count)
    );

    // R5: a redirect leaves nothing for decode in the next cycle
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !ir_valid)
        else $error("R5 instruction offered right after redirect");

    // R7: every request is word-aligned
    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid |-> (fetch_req_addr[1:0] == 2'b00))
        else $error("R7 unaligned fetch address");
endmodule

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        redir_valid;
    logic [31:0] redir_addr;
    logic        fetch_req_valid, fetch_req_ready;
    logic [31:0] fetch_req_addr;
    logic        fetch_rsp_valid;
    logic [31:0] fetch_rsp_data;
    logic        ir_valid, ir_ready;
    logic [15:0] ir_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    prefetch_queue dut (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_addr(fetch_req_addr),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
        .ir_valid(ir_valid), .ir_ready(ir_ready), .ir_data(ir_data)
    );

    function automatic logic [15:0] hw(input logic [31:0] a);
        return (a[16:1] ^ 16'h5A3C) + {a[24:17], 8'h00};
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {hw({a[31:2], 2'b00}), hw({a[31:2], 2'b10})};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus model
    logic [31:0] bq_addr[$];
    int          bq_ep[$];
    int          bq_due[$];

    // reference state
    int          cyc, epoch, occ, live;
    logic [31:0] exp_pc, exp_fetch;
    bit          odd_pending, started, first_out, first_odd;
    bit          prev_stall, prev_redir;
    logic [31:0] prev_addr;

    task automatic run_config(input int lat, input int dpat, input int rpat);
        int ntgt = 0;
        rst_n = 1'b0; redir_valid = 1'b0; redir_addr = '0;
        fetch_req_ready = 1'b0; fetch_rsp_valid = 1'b0; fetch_rsp_data = '0; ir_ready = 1'b0;
        bq_addr.delete(); bq_ep.delete(); bq_due.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0; epoch = 0; occ = 0; live = 0; exp_pc = '0; exp_fetch = '0;
        odd_pending = 0; started = 0; first_out = 0; first_odd = 0;
        prev_stall = 0; prev_redir = 0; prev_addr = '0;
        for (int k = 0; k < 300; k++) begin
            bit redir, rq, rs, dq;
            logic [31:0] tgt;
            @(negedge clk);
            cyc++;
            redir = (cyc == 3) || (cyc > 3 && (cyc % (29 + 4*lat)) == 0) || (cyc == 151);
            tgt   = 32'h400 * ntgt + ((ntgt % 2 == 1) ? 32'd2 : 32'd0) + 32'd8 * dpat;
            if (redir) ntgt++;
            case (rpat)
                0: rq = 1'b1;
                1: rq = (cyc % 2) == 0;
                default: rq = (cyc % 3) != 0;
            endcase
            case (dpat)
                0: dq = 1'b1;
                1: dq = (cyc % 2) == 1;
                2: dq = (cyc % 4) == 0;
                default: dq = (cyc % 5) < 3;
            endcase
            rs = (bq_addr.size() > 0) && (bq_due[0] <= cyc);
            redir_valid     = redir;
            redir_addr      = tgt;
            fetch_req_ready = rq;
            ir_ready        = dq;
            fetch_rsp_valid = rs;
            fetch_rsp_data  = rs ? word_at(bq_addr[0]) : 32'h0;
            #1;
            if (!started) begin
                check(!fetch_req_valid && !ir_valid, "R1", {fetch_req_valid, ir_valid}, 0);
            end else begin
                check(ir_valid == (occ != 0), "R4", ir_valid, occ != 0);
            end
            if (prev_redir)
                check(!ir_valid, "R5", ir_valid, 0);
            if (prev_stall && !prev_redir)
                check(fetch_req_valid && fetch_req_addr == prev_addr, "R10", fetch_req_addr, prev_addr);
            if (fetch_req_valid)
                check(occ + 2*live + 2 <= 4, "R2", occ + 2*live + 2, 4);
            check(bq_addr.size() <= 4, "R9", bq_addr.size(), 4);
            // decode handshake
            if (ir_valid && ir_ready && !redir) begin
                string tag;
                tag = first_out ? (first_odd ? "R8" : "R6") : "R3";
                check(ir_data == hw(exp_pc), tag, ir_data, hw(exp_pc));
                exp_pc += 2; occ--; first_out = 0;
            end
            // response
            if (rs) begin
                if (bq_ep[0] == epoch && !redir) begin
                    live--;
                    occ += odd_pending ? 1 : 2;
                    odd_pending = 0;
                end
                void'(bq_addr.pop_front()); void'(bq_ep.pop_front()); void'(bq_due.pop_front());
            end
            // request
            if (fetch_req_valid && rq) begin
                if (!redir) begin
                    check(fetch_req_addr == exp_fetch, "R7", fetch_req_addr, exp_fetch);
                    exp_fetch += 4; live++;
                end
                bq_addr.push_back(fetch_req_addr); bq_ep.push_back(epoch); bq_due.push_back(cyc + lat);
            end
            prev_stall = fetch_req_valid && !rq;
            prev_addr  = fetch_req_addr;
            prev_redir = redir;
            if (redir) begin
                epoch++; occ = 0; live = 0;
                exp_pc = tgt; exp_fetch = {tgt[31:2], 2'b00};
                odd_pending = tgt[1]; started = 1; first_out = 1; first_odd = tgt[1];
            end
        end
    endtask

    initial begin
        for (int lat = 1; lat <= 3; lat++)
            for (int dp = 0; dp < 4; dp++)
                for (int rp = 0; rp < 3; rp++)
                    run_config(lat, dp, rp);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule